// File: doc/BRIEF.md
# Dual Interpolator Fine Code Selector

Two interpolator lines in a time-to-digital converter each measure every hit. One line takes its reference from the rising clock edge and the other from the falling edge, and each spans slightly more than half a clock period. This block receives one code from each line for every hit. It decides which of the two codes is trustworthy and turns that code into a single fine time that covers the whole clock period and is referenced to the rising edge. A hit that lands right on a clock edge sits in the first bin of one line, and that bin is unreliably wide. In that case the block takes the code from the other line, where the same hit lies well inside the range.

The selection uses only the two code values. A code below a guard threshold is treated as ambiguous. When neither code is ambiguous, the block picks the line whose code has more room to both ends of its range. A falling-line code has a half-period offset added to it. If the sum reaches a full period, it wraps and the coarse count carried with the rising-line code goes up by one.

Each interface is valid/ready. A line's code is transferred when that line's valid and ready are both high. A code that arrives before its partner is held, and that line's ready stays low until the pair is formed. A result stays on the output, unchanged, until the output ready accepts it. When the output register is empty or being drained, a complete pair moves into it at the next edge.

Top module: `fine_code_selector`

## Requirements
- R1: During and right after reset, out_valid is 0 and rise_ready and fall_ready are both 1.
- R2: If exactly one line's code is below GUARD (default 2), the code of the other line is selected.
- R3: If neither code is below GUARD, the line with the larger margin min(code, MAXCODE-code) is selected. A tie selects the rising line.
- R4: If the rising line is selected, out_fine = code and out_line = 0. If the falling line is selected, out_fine = code + HALF_CODES (default 120) and out_line = 1.
- R5: If a falling-line code plus HALF_CODES is at least 2*HALF_CODES, out_fine is that sum minus 2*HALF_CODES, and out_coarse is the rising-line coarse count plus one, modulo 2^COARSE_W. Otherwise out_coarse equals the coarse count that arrived with the rising-line code.
- R6: A code above MAXCODE (default 127) is treated as exactly MAXCODE.
- R7: If both codes are below GUARD, the rising line is selected.
- R8: out_valid rises at the clock edge after the edge at which the second code of a pair is present, when the output is free. A code that arrives first is held, and its line's ready is 0 until its partner arrives.
- R9: While out_valid is 1 and out_ready is 0, out_fine, out_line and out_coarse hold their values. Pairs that arrive during the stall are held in the line buffers, and each is delivered in order once the output is accepted.
- R10: Each pair of codes produces exactly one output transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rise_valid | input | 1 | Rising-line code is offered |
| rise_ready | output | 1 | Rising-line buffer can take a code |
| rise_code | input | CODE_W | Rising-line fine code |
| rise_coarse | input | COARSE_W | Coarse count sampled with the rising-line code |
| fall_valid | input | 1 | Falling-line code is offered |
| fall_ready | output | 1 | Falling-line buffer can take a code |
| fall_code | input | CODE_W | Falling-line fine code |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Downstream accepts the result |
| out_fine | output | FINE_W | Fine time over the full period, rising-edge referenced |
| out_line | output | 1 | Selected line: 0 rising, 1 falling |
| out_coarse | output | COARSE_W | Coarse count aligned with out_fine |

## Verification
The assertions assume that the upstream side follows the valid/ready rules. They also assume that it delivers exactly one rising-line code and one falling-line code per hit, in the same order on both lines, so that the buffered codes always pair up with the right partner. The stimulus sends codes either as a simultaneous pair or as a rising code followed later by its falling partner. It never offers a second code on a line before the first has been paired, and it applies stalls only through out_ready.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic {
    LINE_RISE = 1'b0,
    LINE_FALL = 1'b1
  } line_sel_e;

  localparam int NUM_LINES = 2;

endpackage

// File: rtl/fcs_line_slot.sv
module fcs_line_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         eff_valid,
  output logic [W-1:0] eff_data
);

  logic         full_q;
  logic [W-1:0] held_q;

  assign in_ready  = !full_q;
  assign eff_valid = full_q | in_valid;
  assign eff_data  = full_q ? held_q : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      held_q <= in_data;
    end
  end

  // A parked code stays put until its partner arrives (R8, R9)
  p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(held_q)));

  // Ready is withdrawn once a code is parked (R8)
  p_slot_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !take) |=> !in_ready);

endmodule

// File: rtl/fcs_code_qualify.sv
module fcs_code_qualify #(
  parameter int CODE_W  = 8,
  parameter int MAXCODE = 127,
  parameter int GUARD   = 2
) (
  input  logic [CODE_W-1:0] raw_code,
  output logic [CODE_W-1:0] sat_code,
  output logic              ambiguous,
  output logic [CODE_W-1:0] margin
);

  localparam logic [CODE_W-1:0] MAX_C   = CODE_W'(MAXCODE);
  localparam logic [CODE_W-1:0] GUARD_C = CODE_W'(GUARD);

  logic [CODE_W-1:0] to_top;

  always_comb begin
    sat_code  = (raw_code > MAX_C) ? MAX_C : raw_code;
    ambiguous = (sat_code < GUARD_C);
    to_top    = MAX_C - sat_code;
    margin    = (sat_code < to_top) ? sat_code : to_top;
  end

endmodule

// File: rtl/fcs_merge.sv
module fcs_merge
  import fcs_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int FINE_W     = 9,
  parameter int COARSE_W   = 16,
  parameter int HALF_CODES = 120
) (
  input  logic [CODE_W-1:0]   rise_sat,
  input  logic                rise_amb,
  input  logic [CODE_W-1:0]   rise_margin,
  input  logic [CODE_W-1:0]   fall_sat,
  input  logic                fall_amb,
  input  logic [CODE_W-1:0]   fall_margin,
  input  logic [COARSE_W-1:0] coarse_in,
  output logic [FINE_W-1:0]   fine,
  output line_sel_e           line,
  output logic [COARSE_W-1:0] coarse_out
);

  localparam int SUM_W = FINE_W + 1;
  localparam logic [SUM_W-1:0] HALF_C   = SUM_W'(HALF_CODES);
  localparam logic [SUM_W-1:0] PERIOD_C = SUM_W'(2 * HALF_CODES);

  logic             pick_fall;
  logic [SUM_W-1:0] shifted;
  logic             wraps;

  always_comb begin
    if (rise_amb != fall_amb) begin
      pick_fall = rise_amb;
    end else if (!rise_amb) begin
      pick_fall = (fall_margin > rise_margin);
    end else begin
      pick_fall = 1'b0;
    end

    shifted = SUM_W'(fall_sat) + HALF_C;
    wraps   = (shifted >= PERIOD_C);

    if (pick_fall) begin
      line       = LINE_FALL;
      fine       = wraps ? FINE_W'(shifted - PERIOD_C) : FINE_W'(shifted);
      coarse_out = wraps ? coarse_in + COARSE_W'(1) : coarse_in;
    end else begin
      line       = LINE_RISE;
      fine       = FINE_W'(rise_sat);
      coarse_out = coarse_in;
    end
  end

endmodule

// File: rtl/fine_code_selector.sv
module fine_code_selector
  import fcs_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int MAXCODE    = 127,
  parameter int GUARD      = 2,
  parameter int HALF_CODES = 120,
  parameter int FINE_W     = 9,
  parameter int COARSE_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_valid,
  output logic                rise_ready,
  input  logic [CODE_W-1:0]   rise_code,
  input  logic [COARSE_W-1:0] rise_coarse,
  input  logic                fall_valid,
  output logic                fall_ready,
  input  logic [CODE_W-1:0]   fall_code,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [FINE_W-1:0]   out_fine,
  output logic                out_line,
  output logic [COARSE_W-1:0] out_coarse
);

  localparam int PERIOD_CODES = 2 * HALF_CODES;
  localparam int RISE_W       = CODE_W + COARSE_W;

  logic                eff_valid [NUM_LINES];
  logic [CODE_W-1:0]   eff_code  [NUM_LINES];
  logic [CODE_W-1:0]   sat_code  [NUM_LINES];
  logic                amb       [NUM_LINES];
  logic [CODE_W-1:0]   margin    [NUM_LINES];
  logic [RISE_W-1:0]   rise_eff;
  logic [COARSE_W-1:0] eff_coarse;
  logic                out_can;
  logic                fire;
  logic [FINE_W-1:0]   m_fine;
  line_sel_e           m_line;
  logic [COARSE_W-1:0] m_coarse;

  assign out_can = !out_valid || out_ready;
  assign fire    = eff_valid[0] && eff_valid[1] && out_can;

  fcs_line_slot #(.W(RISE_W)) u_rise_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rise_valid),
    .in_ready  (rise_ready),
    .in_data   ({rise_coarse, rise_code}),
    .take      (fire),
    .eff_valid (eff_valid[0]),
    .eff_data  (rise_eff)
  );

  assign eff_code[0] = rise_eff[CODE_W-1:0];
  assign eff_coarse  = rise_eff[RISE_W-1:CODE_W];

  fcs_line_slot #(.W(CODE_W)) u_fall_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (fall_valid),
    .in_ready  (fall_ready),
    .in_data   (fall_code),
    .take      (fire),
    .eff_valid (eff_valid[1]),
    .eff_data  (eff_code[1])
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_qual
    fcs_code_qualify #(
      .CODE_W  (CODE_W),
      .MAXCODE (MAXCODE),
      .GUARD   (GUARD)
    ) u_qual (
      .raw_code  (eff_code[g]),
      .sat_code  (sat_code[g]),
      .ambiguous (amb[g]),
      .margin    (margin[g])
    );
  end

  fcs_merge #(
    .CODE_W     (CODE_W),
    .FINE_W     (FINE_W),
    .COARSE_W   (COARSE_W),
    .HALF_CODES (HALF_CODES)
  ) u_merge (
    .rise_sat    (sat_code[0]),
    .rise_amb    (amb[0]),
    .rise_margin (margin[0]),
    .fall_sat    (sat_code[1]),
    .fall_amb    (amb[1]),
    .fall_margin (margin[1]),
    .coarse_in   (eff_coarse),
    .fine        (m_fine),
    .line        (m_line),
    .coarse_out  (m_coarse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fine   <= '0;
      out_line   <= 1'b0;
      out_coarse <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_fine   <= m_fine;
      out_line   <= m_line;
      out_coarse <= m_coarse;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // Result is frozen under back-pressure (R9)
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_fine) && $stable(out_line) && $stable(out_coarse)));

  // Fine time never leaves one clock period (R5)
  p_fine_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fine < FINE_W'(PERIOD_CODES)));

  // Rising-line results stay inside the saturated code range (R4, R6)
  p_rise_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_line == LINE_RISE) |-> (out_fine <= FINE_W'(MAXCODE)));

  // An ambiguous rising code with a clean partner is never chosen (R2)
  p_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && amb[0] && !amb[1]) |=> (out_line == LINE_FALL));

  // A stalled output drops no pair and loads nothing new (R10)
  p_one_per_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_valid[0] && eff_valid[1] && !out_can) |=> out_valid);

endmodule

// File: tb/fine_code_selector_tb.sv
module fine_code_selector_tb;

  localparam int MAXC   = 127;
  localparam int GRD    = 2;
  localparam int HALF   = 120;
  localparam int PERIOD = 2 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rise_valid = 1'b0;
  logic        rise_ready;
  logic [7:0]  rise_code = '0;
  logic [15:0] rise_coarse = '0;
  logic        fall_valid = 1'b0;
  logic        fall_ready;
  logic [7:0]  fall_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [8:0]  out_fine;
  logic        out_line;
  logic [15:0] out_coarse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fine_code_selector u_dut (
    .clk (clk), .rst_n (rst_n),
    .rise_valid (rise_valid), .rise_ready (rise_ready),
    .rise_code (rise_code), .rise_coarse (rise_coarse),
    .fall_valid (fall_valid), .fall_ready (fall_ready),
    .fall_code (fall_code),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_fine (out_fine), .out_line (out_line), .out_coarse (out_coarse)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic void model(input int r, input int f, input int c,
                                output int fine, output int line, output int coarse);
    int rs, fs, rm, fm;
    bit ra, fa, pf;
    rs = (r > MAXC) ? MAXC : r;
    fs = (f > MAXC) ? MAXC : f;
    ra = rs < GRD;
    fa = fs < GRD;
    rm = (rs < MAXC - rs) ? rs : MAXC - rs;
    fm = (fs < MAXC - fs) ? fs : MAXC - fs;
    if (ra != fa) pf = ra;
    else if (!ra) pf = fm > rm;
    else pf = 0;
    coarse = c;
    if (pf) begin
      line = 1;
      fine = fs + HALF;
      if (fine >= PERIOD) begin
        fine -= PERIOD;
        coarse = (c + 1) % 65536;
      end
    end else begin
      line = 0;
      fine = rs;
    end
  endfunction

  task automatic check_out(input string req, input int r, input int f, input int c);
    int ef, el, ec;
    model(r, f, c, ef, el, ec);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " fine"}, int'(out_fine), ef);
    check({req, " line"}, int'(out_line), el);
    check({req, " coarse"}, int'(out_coarse), ec);
  endtask

  // Simultaneous pair, output ready (R4, R8, R10)
  task automatic send_pair(input string req, input int r, input int f, input int c);
    @(negedge clk);
    rise_valid = 1'b1; rise_code = 8'(r); rise_coarse = 16'(c);
    fall_valid = 1'b1; fall_code = 8'(f);
    @(negedge clk);
    rise_valid = 1'b0; fall_valid = 1'b0;
    check_out(req, r, f, c);
    @(negedge clk);
    check({req, " R10 single transfer"}, int'(out_valid), 0);
  endtask

  task automatic test_reset();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 rise_ready", int'(rise_ready), 1);
    check("R1 fall_ready", int'(fall_ready), 1);
  endtask

  task automatic test_guard();
    send_pair("R2 fall ambiguous", 60, 0, 100);
    send_pair("R2 rise ambiguous", 1, 115, 200);
  endtask

  task automatic test_margin();
    send_pair("R3 fall wider margin", 10, 50, 7);
    send_pair("R3 rise wider margin", 60, 20, 8);
    send_pair("R3 tie picks rise", 30, 30, 9);
    send_pair("R4 high end margin", 120, 100, 11);
  endtask

  task automatic test_wrap();
    send_pair("R5 wrap", 1, 125, 300);
    send_pair("R5 coarse rollover", 0, 125, 65535);
  endtask

  task automatic test_saturate();
    send_pair("R6 sat rise", 250, 0, 12);
    send_pair("R6 sat rise vs fall", 200, 3, 13);
  endtask

  task automatic test_both_amb();
    send_pair("R7 both ambiguous", 1, 0, 14);
  endtask

  task automatic test_staggered();
    @(negedge clk);
    rise_valid = 1'b1; rise_code = 8'd40; rise_coarse = 16'd500;
    @(negedge clk);
    rise_valid = 1'b0; rise_coarse = 16'd999;
    check("R8 no early output", int'(out_valid), 0);
    check("R8 rise held ready low", int'(rise_ready), 0);
    check("R8 fall ready", int'(fall_ready), 1);
    @(negedge clk);
    check("R8 still waiting", int'(out_valid), 0);
    fall_valid = 1'b1; fall_code = 8'd70;
    @(negedge clk);
    fall_valid = 1'b0;
    check_out("R8 staggered", 40, 70, 500);
    check("R8 rise ready back", int'(rise_ready), 1);
    @(negedge clk);
  endtask

  task automatic test_stall();
    int f0, l0, c0;
    out_ready = 1'b0;
    @(negedge clk);
    rise_valid = 1'b1; rise_code = 8'd90; rise_coarse = 16'd21;
    fall_valid = 1'b1; fall_code = 8'd5;
    @(negedge clk);
    check_out("R9 first", 90, 5, 21);
    rise_code = 8'd3; rise_coarse = 16'd22; fall_code = 8'd64;
    @(negedge clk);
    rise_valid = 1'b0; fall_valid = 1'b0;
    check_out("R9 hold", 90, 5, 21);
    check("R9 rise parked", int'(rise_ready), 0);
    check("R9 fall parked", int'(fall_ready), 0);
    @(negedge clk);
    check_out("R9 still held", 90, 5, 21);
    out_ready = 1'b1;
    @(negedge clk);
    check_out("R9 second", 3, 64, 22);
    check("R9 slots free", int'(rise_ready & fall_ready), 1);
    @(negedge clk);
    check("R10 drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_guard();
    test_margin();
    test_wrap();
    test_saturate();
    test_both_amb();
    test_staggered();
    test_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule